// File: doc/BRIEF.md
# Seven-to-four lane gearbox with forwarded clock lane

This block sits between the pixel pipeline and a 2x-geared DDR output stage on a source-synchronous 7:1 video link. Once per pixel it takes 8-bit red, green and blue values and the three sync/enable flags. It packs them into four 7-bit lane words and regears every lane from 7 bits per pixel to 4 bits per SCLK period. A fifth lane carries the forwarded clock as the constant word 1100011. That word passes through an identical gearbox, so the clock and data lanes keep a fixed phase to each other.

A single base clock runs at the serial bit rate. An internal timer divides it into 28-cycle frames. The pixel strobe marks every seventh cycle and the SCLK enable marks every fourth cycle, so each frame holds four pixels and seven nibbles. Each lane writes a frame into one half of a two-bank 28-bit store while the other half is read out nibble by nibble. The downstream DDR stage consumes a registered nibble per SCLK enable.

Top module: `vid_gear_tx`

## Requirements
- R1: Counting the first rising edge after reset release as cycle 0, `pix_stb_o` is high exactly in cycles whose index mod 28 is 0, 7, 14 or 21, and `sclk_en_o` is high exactly in cycles whose index is a multiple of 4. While reset is held, both are high.
- R2: The video inputs are sampled only at an edge where `pix_stb_o` is high. Values present in any other cycle have no effect on the outputs.
- R3: The lane A word, first-sent bit to last-sent bit, is G0, R5, R4, R3, R2, R1, R0.
- R4: The lane B word is B1, B0, G5, G4, G3, G2, G1. The lane C word is DE, VSYNC, HSYNC, B5, B4, B3, B2, in the same first-to-last order.
- R5: The lane D word is reserved, B7, B6, G7, G6, R7, R6, and the reserved bit is always 0.
- R6: The clock lane carries the word 1100011 (first-sent bit leftmost) for every pixel, geared exactly like the data lanes.
- R7: A lane's 28-bit frame sequence is the four words of that frame in strobe order, each word first-sent bit first. Nibble m of a frame carries sequence bits 4m to 4m+3 on nibble bits 0 to 3, so bit 0 goes to DDR slot DA0, bit 1 to DB0, bit 2 to DA1 and bit 3 to DB1. For the clock lane, the first nibble of a frame is therefore 4'b0011.
- R8: Nibble m of frame f (cycle index 28f+4m) carries frame f−1 data. It appears after the rising edge of that cycle and holds until the next SCLK-enable edge. Lane A is bits 3:0 of `data_nib_o`, B is 7:4, C is 11:8 and D is 15:12.
- R9: Asynchronous reset clears all outputs to zero. After release, all outputs, clock lane included, stay zero until the first complete frame has been loaded, i.e. through cycle 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock at the serial bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red component, sampled on pixel strobe |
| grn_i | input | 8 | Green component, sampled on pixel strobe |
| blu_i | input | 8 | Blue component, sampled on pixel strobe |
| hsync_i | input | 1 | Horizontal sync, sampled on pixel strobe |
| vsync_i | input | 1 | Vertical sync, sampled on pixel strobe |
| de_i | input | 1 | Data enable, sampled on pixel strobe |
| pix_stb_o | output | 1 | Pixel accept strobe, once every 7 cycles |
| sclk_en_o | output | 1 | SCLK enable, once every 4 cycles |
| data_nib_o | output | 16 | Four data-lane nibbles for the DDR stage |
| clk_nib_o | output | 4 | Clock-lane nibble for the DDR stage |

## Verification
The hardest case to reach from the ports is the frame boundary. There, a word lands in one bank while the last nibble of the other bank is still being read, and a lane slip there shows up only as a shifted bit several cycles later. The bench tracks the 28-cycle frame itself and drives each pixel only in its strobe cycle, with the bitwise complement on all other cycles. It rebuilds every lane's expected serial sequence from single-bit and all-ones pixels and compares every nibble, bit by bit, one frame later. A reset asserted in the middle of a frame confirms that the zero-fill restarts from a clean frame.

// File: rtl/vid_gear_pkg.sv
package vid_gear_pkg;
  localparam int WORD_W     = 7;
  localparam int NIB_W      = 4;
  localparam int FRAME_W    = WORD_W * NIB_W;
  localparam int DATA_LANES = 4;
  localparam int ALL_LANES  = DATA_LANES + 1;
  localparam int COLOR_W    = 8;
  localparam int PH_W       = $clog2(WORD_W);
  localparam int SLOT_W     = $clog2(NIB_W);
  localparam int IDX_W      = $clog2(FRAME_W);
  localparam logic [WORD_W-1:0] CLK_WORD = 7'b1100011;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/vid_gear_timer.sv
module vid_gear_timer
  import vid_gear_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              pix_stb_o,
  output logic              sclk_en_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [PH_W-1:0]   nib_o,
  output logic              bank_o
);
  logic [PH_W-1:0]   ph_wr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] ph_rd_q;
  logic [PH_W-1:0]   nib_q;
  logic              bank_q;
  logic              wr_wrap, rd_wrap;

  assign wr_wrap = (ph_wr_q == PH_W'(WORD_W-1));
  assign rd_wrap = (ph_rd_q == SLOT_W'(NIB_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_wr_q <= '0;
      slot_q  <= '0;
      ph_rd_q <= '0;
      nib_q   <= '0;
      bank_q  <= 1'b0;
    end else begin
      ph_wr_q <= wr_wrap ? '0 : ph_wr_q + 1'b1;
      if (wr_wrap) begin
        slot_q <= (slot_q == SLOT_W'(NIB_W-1)) ? '0 : slot_q + 1'b1;
        if (slot_q == SLOT_W'(NIB_W-1)) bank_q <= ~bank_q;
      end
      ph_rd_q <= rd_wrap ? '0 : ph_rd_q + 1'b1;
      if (rd_wrap) nib_q <= (nib_q == PH_W'(WORD_W-1)) ? '0 : nib_q + 1'b1;
    end
  end

  assign pix_stb_o = (ph_wr_q == '0);
  assign sclk_en_o = (ph_rd_q == '0);
  assign slot_o    = slot_q;
  assign nib_o     = nib_q;
  assign bank_o    = bank_q;
endmodule

// File: rtl/vid_lane_map.sv
module vid_lane_map
  import vid_gear_pkg::*;
(
  input  logic [COLOR_W-1:0]           red_i,
  input  logic [COLOR_W-1:0]           grn_i,
  input  logic [COLOR_W-1:0]           blu_i,
  input  logic                         hsync_i,
  input  logic                         vsync_i,
  input  logic                         de_i,
  output logic [DATA_LANES*WORD_W-1:0] words_o
);
  // word bit WORD_W-1 is the first bit on the wire
  assign words_o[0*WORD_W +: WORD_W] = {grn_i[0], red_i[5:0]};
  assign words_o[1*WORD_W +: WORD_W] = {blu_i[1:0], grn_i[5:1]};
  assign words_o[2*WORD_W +: WORD_W] = {de_i, vsync_i, hsync_i, blu_i[5:2]};
  assign words_o[3*WORD_W +: WORD_W] = {1'b0, blu_i[7:6], grn_i[7:6], red_i[7:6]};
endmodule

// File: rtl/vid_gear_lane.sv
module vid_gear_lane
  import vid_gear_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_stb_i,
  input  logic              sclk_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PH_W-1:0]   nib_i,
  input  logic              bank_i,
  input  word_t             word_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [FRAME_W-1:0] store_q [2];
  logic [FRAME_W-1:0] rd_buf;
  logic [IDX_W-1:0]   wr_top, rd_top;
  logic [NIB_W-1:0]   nib_q;

  always_comb begin
    wr_top = IDX_W'(FRAME_W-1) - IDX_W'(WORD_W) * IDX_W'(slot_i);
    rd_top = IDX_W'(FRAME_W-1) - IDX_W'(NIB_W) * IDX_W'(nib_i);
    rd_buf = store_q[~bank_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q[0] <= '0;
      store_q[1] <= '0;
      nib_q      <= '0;
    end else begin
      if (pix_stb_i) store_q[bank_i][wr_top -: WORD_W] <= word_i;
      // nibble bit 0 is the earliest serial bit (DA0)
      if (sclk_en_i)
        for (int i = 0; i < NIB_W; i++) nib_q[i] <= rd_buf[rd_top - IDX_W'(i)];
    end
  end

  assign nib_o = nib_q;
endmodule

// File: rtl/vid_gear_tx.sv
module vid_gear_tx
  import vid_gear_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [COLOR_W-1:0]          red_i,
  input  logic [COLOR_W-1:0]          grn_i,
  input  logic [COLOR_W-1:0]          blu_i,
  input  logic                        hsync_i,
  input  logic                        vsync_i,
  input  logic                        de_i,
  output logic                        pix_stb_o,
  output logic                        sclk_en_o,
  output logic [DATA_LANES*NIB_W-1:0] data_nib_o,
  output logic [NIB_W-1:0]            clk_nib_o
);
  logic [SLOT_W-1:0]              slot;
  logic [PH_W-1:0]                nib_idx;
  logic                           bank;
  logic [DATA_LANES*WORD_W-1:0]   data_words;
  logic [ALL_LANES*NIB_W-1:0]     lane_nib;

  vid_gear_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_stb_o (pix_stb_o),
    .sclk_en_o (sclk_en_o),
    .slot_o    (slot),
    .nib_o     (nib_idx),
    .bank_o    (bank)
  );

  vid_lane_map u_map (
    .red_i   (red_i),
    .grn_i   (grn_i),
    .blu_i   (blu_i),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .de_i    (de_i),
    .words_o (data_words)
  );

  for (genvar l = 0; l < ALL_LANES; l++) begin : g_lane
    word_t lane_word;
    if (l < DATA_LANES) begin : g_data
      assign lane_word = data_words[l*WORD_W +: WORD_W];
    end else begin : g_clk
      assign lane_word = CLK_WORD;
    end
    vid_gear_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pix_stb_i (pix_stb_o),
      .sclk_en_i (sclk_en_o),
      .slot_i    (slot),
      .nib_i     (nib_idx),
      .bank_i    (bank),
      .word_i    (lane_word),
      .nib_o     (lane_nib[l*NIB_W +: NIB_W])
    );
  end

  assign data_nib_o = lane_nib[DATA_LANES*NIB_W-1:0];
  assign clk_nib_o  = lane_nib[ALL_LANES*NIB_W-1 -: NIB_W];
endmodule

// File: rtl/vid_gear_tx_chk.sv
module vid_gear_tx_chk
  import vid_gear_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        pix_stb_o,
  input logic                        sclk_en_o,
  input logic [DATA_LANES*NIB_W-1:0] data_nib_o,
  input logic [NIB_W-1:0]            clk_nib_o
);
  localparam int QUIET = FRAME_W;
  localparam int CYC_W = $clog2(QUIET + 2);
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q <= CYC_W'(QUIET)) cyc_q <= cyc_q + 1'b1;
  end

  // R1: strobes never fire on back-to-back cycles
  a_r1_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_o |=> !pix_stb_o);
  a_r1_sclk_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |=> !sclk_en_o);
  // R8: nibbles move only on an SCLK enable edge
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_o |=> $stable({clk_nib_o, data_nib_o}));
  // R9: silent until the first frame is loaded
  a_r9_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q <= CYC_W'(QUIET)) |-> ({clk_nib_o, data_nib_o} == '0));
endmodule

bind vid_gear_tx vid_gear_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_stb_o  (pix_stb_o),
  .sclk_en_o  (sclk_en_o),
  .data_nib_o (data_nib_o),
  .clk_nib_o  (clk_nib_o)
);

// File: tb/vid_gear_tx_bench.sv
module vid_gear_tx_bench;
  import vid_gear_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int OW = ALL_LANES * NIB_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] red, grn, blu;
  logic hsync, vsync, de;
  logic pix_stb_o, sclk_en_o;
  logic [DATA_LANES*NIB_W-1:0] data_nib_o;
  logic [NIB_W-1:0] clk_nib_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_gear_tx u_vid_gear_tx (
    .clk_i(clk), .rst_ni(rst_ni), .red_i(red), .grn_i(grn), .blu_i(blu),
    .hsync_i(hsync), .vsync_i(vsync), .de_i(de), .pix_stb_o(pix_stb_o),
    .sclk_en_o(sclk_en_o), .data_nib_o(data_nib_o), .clk_nib_o(clk_nib_o)
  );

  // {red, grn, blu, hs, vs, de, A, B, C, D}; lane words first-sent bit leftmost
  localparam logic [54:0] VEC [12] = '{
    {8'h00, 8'h00, 8'h00, 3'b000, 7'b0000000, 7'b0000000, 7'b0000000, 7'b0000000},
    {8'h01, 8'h00, 8'h00, 3'b000, 7'b0000001, 7'b0000000, 7'b0000000, 7'b0000000},
    {8'h80, 8'h00, 8'h00, 3'b000, 7'b0000000, 7'b0000000, 7'b0000000, 7'b0000010},
    {8'h00, 8'h01, 8'h00, 3'b000, 7'b1000000, 7'b0000000, 7'b0000000, 7'b0000000},
    {8'h00, 8'h20, 8'h00, 3'b000, 7'b0000000, 7'b0010000, 7'b0000000, 7'b0000000},
    {8'h00, 8'h00, 8'h04, 3'b000, 7'b0000000, 7'b0000000, 7'b0000001, 7'b0000000},
    {8'h00, 8'h00, 8'h00, 3'b001, 7'b0000000, 7'b0000000, 7'b1000000, 7'b0000000},
    {8'h00, 8'h00, 8'h00, 3'b110, 7'b0000000, 7'b0000000, 7'b0110000, 7'b0000000},
    {8'h00, 8'h00, 8'h80, 3'b000, 7'b0000000, 7'b0000000, 7'b0000000, 7'b0100000},
    {8'hFF, 8'hFF, 8'hFF, 3'b111, 7'b1111111, 7'b1111111, 7'b1111111, 7'b0111111},
    {8'h3F, 8'h00, 8'h00, 3'b000, 7'b0111111, 7'b0000000, 7'b0000000, 7'b0000000},
    {8'h00, 8'h40, 8'h01, 3'b000, 7'b0000000, 7'b0100000, 7'b0000000, 7'b0000100}
  };

  logic [FRAME_W-1:0] cur_s  [ALL_LANES];
  logic [FRAME_W-1:0] prev_s [ALL_LANES];
  logic [OW-1:0] snap;

  function automatic logic [OW-1:0] outs();
    return {clk_nib_o, data_nib_o};
  endfunction

  function automatic string lane_tag(int l);
    case (l)
      0: return "R3";
      1: return "R4";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [54:0] v, bit inv);
    logic [26:0] f;
    f = inv ? ~v[54:28] : v[54:28];
    {red, grn, blu, hsync, vsync, de} = f;
  endtask

  task automatic run_frame(int base, bit blank, bit zero_exp, string dtag);
    logic [54:0] pix [4];
    for (int k = 0; k < 4; k++) pix[k] = blank ? '0 : VEC[base + k];
    for (int l = 0; l < ALL_LANES; l++)
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < WORD_W; j++)
          cur_s[l][7*k + j] = (l < DATA_LANES) ? pix[k][27 - 7*l - j] : CLK_WORD[6 - j];
    for (int t = 0; t < FRAME_W; t++) begin
      @(negedge clk);
      if (t >= 1 && (t - 1) % 4 == 0) begin
        int m;
        m = (t - 1) / 4;
        for (int l = 0; l < ALL_LANES; l++) begin
          logic [3:0] e;
          string tg;
          e  = zero_exp ? 4'h0 : prev_s[l][4*m +: 4];
          tg = (dtag != "" && (l < DATA_LANES || zero_exp)) ? dtag : lane_tag(l);
          chk(tg, 32'(outs() >> (4*l)) & 32'hF, 32'(e));
        end
        if (!zero_exp && m == 0) chk("R7", 32'(clk_nib_o), 32'h3);
      end else if (t >= 2) begin
        chk("R8", 32'(outs()), 32'(snap));
      end
      snap = outs();
      chk("R1", {30'd0, pix_stb_o, sclk_en_o}, {30'd0, t % 7 == 0, t % 4 == 0});
      drive(pix[t / 7], t % 7 != 0);
      @(posedge clk);
    end
    for (int l = 0; l < ALL_LANES; l++) prev_s[l] = cur_s[l];
  endtask

  initial begin
    drive('0, 1'b0);
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", 32'(outs()), 32'h0);
    chk("R1", {30'd0, pix_stb_o, sclk_en_o}, 32'h3);
    rst_ni = 1'b1;
    run_frame(0, 1'b0, 1'b1, "R9");
    run_frame(4, 1'b0, 1'b0, "");
    run_frame(8, 1'b0, 1'b0, "");
    run_frame(0, 1'b1, 1'b0, "");
    run_frame(0, 1'b0, 1'b0, "R2");
    run_frame(4, 1'b1, 1'b0, "");
    // reset in the middle of a frame
    drive(VEC[9], 1'b0);
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9", 32'(outs()), 32'h0);
    chk("R1", {30'd0, pix_stb_o, sclk_en_o}, 32'h3);
    repeat (2) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    run_frame(8, 1'b0, 1'b1, "R9");
    run_frame(4, 1'b0, 1'b0, "");
    run_frame(0, 1'b1, 1'b0, "");
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule